// File: doc/BRIEF.md
# Low-Power Auto-Reload Event Timer

This block is a wake-up event timer that software controls through a small register bus. A 16-bit up-counter advances on ticks from a power-of-two prescaler. When the count equals a programmed reload value, the counter returns to zero and a match flag is set. The flag drives an interrupt line when its enable bit is set, and it stays pending until software clears it.

Counting begins only on an explicit start command written to the control register together with the enable bit. A one-shot start stops the counter after the first match. A periodic start keeps the counter cycling. The enable bit decides which registers may be written. The interrupt enable can be written only while the timer is disabled. The reload value can be written only while the timer is enabled. Writes blocked by these rules are dropped.

Top module: `lp_evt_timer`

## Requirements
- R1: After reset, every readable register (control 0x00, config 0x04, irq-enable 0x08, status 0x0C, reload 0x14, counter 0x18) reads 0 and irq_o is low.
- R2: The prescaler code in config bits [11:9] selects a division of 2^code (1 to 128): while running, the counter advances once every 2^code clock cycles.
- R3: With reload value R, the first match occurs at the (R+1)*2^code-th rising edge after the edge that captured the start write. At that edge the counter returns to 0 and status bit 0 (match flag) is set.
- R4: A control write with bit 0 (enable) and bit 2 (periodic start) set starts periodic counting, which keeps matching every (R+1)*2^code cycles.
- R5: A control write with bit 0 and bit 1 (one-shot start) set starts one-shot counting: after the first match the counter stays at 0. If both start bits are written together, one-shot wins.
- R6: A write to the irq-enable register (bit 0) is ignored while the control enable bit is set.
- R7: A write to the reload register (bits [15:0]) is ignored while the control enable bit is clear.
- R8: irq_o is high exactly when the match flag and the irq-enable bit are both set, and it stays high until the flag is cleared.
- R9: Writing 1 to bit 0 of the clear register (0x10) clears the match flag. A match in the same cycle wins over the clear.
- R10: Writing zero to the control register stops counting, returns the counter to 0 and clears the enable bit.
- R11: Start bits written without the enable bit have no effect. Control reads back only the enable bit, and start bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_o | output | 1 | Match interrupt, level |

## Verification
Read data is combinational, so a register value is checked in the same cycle its address is presented. A register write takes effect at the edge that captures the strobe, so readback is checked one cycle later. A match is due a fixed (R+1)*2^code edges after the start edge. The bench counts falling edges from the one that follows the start edge and requires the flag to appear at exactly that count, not within a window. For periodic runs, the flag clear lands two edges after the first match, so the next match is expected (R+1)*2^code-2 edges after the clear. Level outputs such as irq_o and a held counter are sampled again several cycles later to show they stay put.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    // Register byte offsets (decoded by the register block)
    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_CFG    = 8'h04;
    localparam logic [7:0] OFS_IEN    = 8'h08;
    localparam logic [7:0] OFS_STAT   = 8'h0C;
    localparam logic [7:0] OFS_CLR    = 8'h10;
    localparam logic [7:0] OFS_RELOAD = 8'h14;
    localparam logic [7:0] OFS_COUNT  = 8'h18;

    // Control bit positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_ONCE_BIT = 1;
    localparam int CTRL_LOOP_BIT = 2;

    // Prescaler field position in config
    localparam int PSC_LSB = 9;

    // Match flag position in status, irq-enable and clear
    localparam int MATCH_BIT = 0;

    typedef enum logic {
        RUN_ONCE = 1'b0,
        RUN_LOOP = 1'b1
    } run_mode_e;

    typedef struct packed {
        logic      start;
        logic      stop;
        run_mode_e mode;
    } tmr_cmd_t;

    // Low-ones mask for a prescaler code: divide by 2^code
    function automatic logic [7:0] div_mask(input logic [2:0] code);
        logic [7:0] m;
        m = '0;
        for (int i = 0; i < 8; i++) begin
            if (i < int'(code)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/lpt_regs.sv
module lpt_regs
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              flag_i,
    output logic              enable_o,
    output logic              ien_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [PSC_W-1:0]  psc_o,
    output tmr_cmd_t          cmd_o,
    output logic              clr_flag_o
);

    logic              enable_q;
    logic              ien_q;
    logic [CNT_W-1:0]  reload_q;
    logic [PSC_W-1:0]  psc_q;

    logic wr_ctrl, wr_cfg, wr_ien, wr_clr, wr_reload;

    always_comb begin
        wr_ctrl   = bus_we && (bus_addr == OFS_CTRL[ADDR_W-1:0]);
        wr_cfg    = bus_we && (bus_addr == OFS_CFG[ADDR_W-1:0]);
        wr_ien    = bus_we && (bus_addr == OFS_IEN[ADDR_W-1:0]);
        wr_clr    = bus_we && (bus_addr == OFS_CLR[ADDR_W-1:0]);
        wr_reload = bus_we && (bus_addr == OFS_RELOAD[ADDR_W-1:0]);
    end

    // Command decode: start requires enable in the same write
    always_comb begin
        cmd_o.stop  = wr_ctrl && !bus_wdata[CTRL_EN_BIT];
        cmd_o.start = wr_ctrl && bus_wdata[CTRL_EN_BIT]
                      && (bus_wdata[CTRL_ONCE_BIT] || bus_wdata[CTRL_LOOP_BIT]);
        cmd_o.mode  = bus_wdata[CTRL_ONCE_BIT] ? RUN_ONCE : RUN_LOOP;
        clr_flag_o  = wr_clr && bus_wdata[MATCH_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable_q <= 1'b0;
            ien_q    <= 1'b0;
            reload_q <= '0;
            psc_q    <= '0;
        end else begin
            if (wr_ctrl) enable_q <= bus_wdata[CTRL_EN_BIT];
            if (wr_cfg) psc_q <= bus_wdata[PSC_LSB +: PSC_W];
            if (wr_ien && !enable_q) ien_q <= bus_wdata[MATCH_BIT];
            if (wr_reload && enable_q) reload_q <= bus_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL[ADDR_W-1:0]:   bus_rdata[CTRL_EN_BIT] = enable_q;
            OFS_CFG[ADDR_W-1:0]:    bus_rdata[PSC_LSB +: PSC_W] = psc_q;
            OFS_IEN[ADDR_W-1:0]:    bus_rdata[MATCH_BIT] = ien_q;
            OFS_STAT[ADDR_W-1:0]:   bus_rdata[MATCH_BIT] = flag_i;
            OFS_RELOAD[ADDR_W-1:0]: bus_rdata[CNT_W-1:0] = reload_q;
            OFS_COUNT[ADDR_W-1:0]:  bus_rdata[CNT_W-1:0] = cnt_i;
            default:                bus_rdata = '0;
        endcase
    end

    assign enable_o = enable_q;
    assign ien_o    = ien_q;
    assign reload_o = reload_q;
    assign psc_o    = psc_q;

endmodule

// File: rtl/lpt_prescaler.sv
module lpt_prescaler
    import lpt_pkg::*;
#(
    parameter int PSC_W = 3,
    localparam int DIV_W = (1 << PSC_W) - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [PSC_W-1:0] code_i,
    output logic             tick_o
);

    logic [DIV_W-1:0] pcnt_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask   = DIV_W'(div_mask(3'(code_i)));
        tick_o = run_i && ((pcnt_q & mask) == mask);
    end

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            pcnt_q <= '0;
        end else if (run_i) begin
            pcnt_q <= pcnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lpt_counter.sv
module lpt_counter
    import lpt_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  tmr_cmd_t         cmd_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] reload_i,
    input  logic             clr_flag_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             running_o,
    output run_mode_e        mode_o,
    output logic             flag_o
);

    logic [CNT_W-1:0] cnt_q;
    logic             running_q;
    run_mode_e        mode_q;
    logic             flag_q;
    logic             hit;

    always_comb begin
        hit = running_q && tick_i && (cnt_q == reload_i)
              && !cmd_i.start && !cmd_i.stop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            running_q <= 1'b0;
            mode_q    <= RUN_ONCE;
            flag_q    <= 1'b0;
        end else begin
            if (hit) flag_q <= 1'b1;
            else if (clr_flag_i) flag_q <= 1'b0;

            if (cmd_i.stop) begin
                running_q <= 1'b0;
                cnt_q     <= '0;
            end else if (cmd_i.start) begin
                running_q <= 1'b1;
                cnt_q     <= '0;
                mode_q    <= cmd_i.mode;
            end else if (running_q && tick_i) begin
                if (cnt_q == reload_i) begin
                    cnt_q <= '0;
                    if (mode_q == RUN_ONCE) running_q <= 1'b0;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign cnt_o     = cnt_q;
    assign running_o = running_q;
    assign mode_o    = mode_q;
    assign flag_o    = flag_q;

endmodule

// File: rtl/lp_evt_timer.sv
module lp_evt_timer
    import lpt_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);

    logic             enable;
    logic             ien;
    logic [CNT_W-1:0] reload;
    logic [PSC_W-1:0] psc;
    tmr_cmd_t         cmd;
    logic             clr_flag;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             running;
    run_mode_e        mode;
    logic             flag;

    lpt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)
    ) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata),
        .cnt_i(cnt), .flag_i(flag),
        .enable_o(enable), .ien_o(ien), .reload_o(reload), .psc_o(psc),
        .cmd_o(cmd), .clr_flag_o(clr_flag)
    );

    lpt_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst(rst),
        .run_i(running),
        .restart_i(cmd.start || cmd.stop),
        .code_i(psc),
        .tick_o(tick)
    );

    lpt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst),
        .cmd_i(cmd), .tick_i(tick), .reload_i(reload), .clr_flag_i(clr_flag),
        .cnt_o(cnt), .running_o(running), .mode_o(mode), .flag_o(flag)
    );

    assign irq_o = flag && ien;

endmodule

// File: rtl/lpt_checker.sv
module lpt_checker #(
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_we,
    input logic              irq_o,
    input logic              enable,
    input logic              ien,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic              running,
    input logic              loop_mode,
    input logic              tick
);

    logic wr_ctrl, wr_clr, wr_ien;
    assign wr_ctrl = bus_we && (bus_addr == ADDR_W'(8'h00));
    assign wr_ien  = bus_we && (bus_addr == ADDR_W'(8'h08));
    assign wr_clr  = bus_we && (bus_addr == ADDR_W'(8'h10)) && bus_wdata[0];

    // R1
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (cnt == '0) && !flag && !irq_o && !enable);

    // R2
    a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        running && !tick && !wr_ctrl |=> $stable(cnt));

    // R3
    a_r3_wrap_sets_flag: assert property (@(posedge clk) disable iff (rst)
        running && tick && (cnt == reload) && !wr_ctrl |=> (cnt == '0) && flag);

    // R4
    a_r4_loop_keeps_running: assert property (@(posedge clk) disable iff (rst)
        running && loop_mode && !wr_ctrl |=> running);

    // R5
    a_r5_once_stops: assert property (@(posedge clk) disable iff (rst)
        running && !loop_mode && tick && (cnt == reload) && !wr_ctrl |=> !running);

    // R6
    a_r6_ien_locked: assert property (@(posedge clk) disable iff (rst)
        enable |=> $stable(ien));

    // R7
    a_r7_reload_locked: assert property (@(posedge clk) disable iff (rst)
        !enable |=> $stable(reload));

    // R8
    a_r8_irq_held: assert property (@(posedge clk) disable iff (rst)
        irq_o && !wr_clr && !(wr_ien && !enable) |=> irq_o);

    // R10
    a_r10_stop: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl && (bus_wdata == '0) |=> !enable && !running && (cnt == '0));

endmodule

bind lp_evt_timer lpt_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_lpt_checker (
    .clk(clk), .rst(rst),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .irq_o(irq_o),
    .enable(enable), .ien(ien), .reload(reload), .cnt(cnt), .flag(flag),
    .running(running), .loop_mode(mode == lpt_pkg::RUN_LOOP), .tick(tick)
);

// File: tb/lp_evt_timer_bench.sv
module lp_evt_timer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 7;
    localparam int WAIT_CAP = 2000;

    localparam logic [4:0] A_CTRL = 5'h00, A_CFG = 5'h04, A_IEN = 5'h08,
                           A_STAT = 5'h0C, A_CLR = 5'h10, A_RLD = 5'h14,
                           A_CNT = 5'h18;

    typedef struct packed {
        logic [2:0]  code;
        logic [15:0] reload;
        logic        loop;
        logic [15:0] period;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{3'd0, 16'd5, 1'b1, 16'd6},
        '{3'd1, 16'd3, 1'b0, 16'd8},
        '{3'd3, 16'd2, 1'b1, 16'd24},
        '{3'd7, 16'd1, 1'b0, 16'd256},
        '{3'd2, 16'd0, 1'b1, 16'd4},
        '{3'd0, 16'd0, 1'b0, 16'd1},
        '{3'd4, 16'd9, 1'b1, 16'd160}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    lp_evt_timer u_lp_evt_timer (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Counts falling edges until the match flag is seen
    task automatic wait_flag(output int n);
        logic [31:0] v;
        n = 0;
        rd(A_STAT, v);
        while (!v[0] && n < WAIT_CAP) begin
            @(negedge clk);
            n++;
            rd(A_STAT, v);
        end
    endtask

    initial begin
        logic [31:0] v;
        int n;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        rd(A_CTRL, v);   check(v == 0, "R1 ctrl", v, 0);
        rd(A_CFG, v);    check(v == 0, "R1 cfg", v, 0);
        rd(A_IEN, v);    check(v == 0, "R1 ien", v, 0);
        rd(A_STAT, v);   check(v == 0, "R1 status", v, 0);
        rd(A_RLD, v);    check(v == 0, "R1 reload", v, 0);
        rd(A_CNT, v);    check(v == 0, "R1 counter", v, 0);
        check(irq_o == 0, "R1 irq", irq_o, 0);

        // Table of match-timing vectors (R2, R3, R4, R5, R8)
        for (int i = 0; i < NVEC; i++) begin
            wr(A_CTRL, 32'h0);
            wr(A_CLR, 32'h1);
            wr(A_IEN, 32'h1);
            wr(A_CFG, 32'(VECS[i].code) << 9);
            wr(A_CTRL, 32'h1);
            wr(A_RLD, 32'(VECS[i].reload));
            wr(A_CTRL, VECS[i].loop ? 32'h5 : 32'h3);
            wait_flag(n);
            check(n == int'(VECS[i].period), "R3 first match cycle", n, VECS[i].period);
            check(irq_o == 1'b1, "R8 irq on match", irq_o, 1);
            if (VECS[i].loop) begin
                wr(A_CLR, 32'h1);
                wait_flag(n);
                check(n == int'(VECS[i].period) - 2, "R4 periodic rematch", n,
                      int'(VECS[i].period) - 2);
            end else begin
                idle(20);
                rd(A_CNT, v);
                check(v == 0, "R5 one-shot counter held", v, 0);
                rd(A_STAT, v);
                check(v[0] == 1'b1, "R8 flag held", v[0], 1);
                check(irq_o == 1'b1, "R8 irq held", irq_o, 1);
            end
        end

        // R2: mid-count value with divide by 4
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h1);
        wr(A_CFG, 32'd2 << 9);
        wr(A_CTRL, 32'h1);
        wr(A_RLD, 32'd100);
        wr(A_CTRL, 32'h5);
        idle(9);
        rd(A_CNT, v);
        check(v == 2, "R2 count after 9 cycles div4", v, 2);

        // R10: stop clears counter and enable
        wr(A_CTRL, 32'h0);
        rd(A_CNT, v);  check(v == 0, "R10 counter zero", v, 0);
        rd(A_CTRL, v); check(v == 0, "R10 enable clear", v, 0);
        idle(5);
        rd(A_CNT, v);  check(v == 0, "R10 counter stays", v, 0);

        // R7: reload write ignored while disabled
        wr(A_RLD, 32'h1234);
        rd(A_RLD, v);  check(v == 100, "R7 reload locked", v, 100);

        // R6: irq-enable write ignored while enabled
        wr(A_IEN, 32'h0);
        wr(A_CTRL, 32'h1);
        wr(A_IEN, 32'h1);
        rd(A_IEN, v);  check(v == 0, "R6 ien locked", v, 0);

        // R11: start without enable has no effect
        wr(A_CTRL, 32'h0);
        wr(A_CFG, 32'h0);
        wr(A_CTRL, 32'h2);
        rd(A_CTRL, v); check(v == 0, "R11 ctrl readback no enable", v, 0);
        idle(5);
        rd(A_CNT, v);  check(v == 0, "R11 counter idle", v, 0);

        // R5/R11: both start bits -> one-shot; ctrl reads only enable
        wr(A_CTRL, 32'h1);
        wr(A_RLD, 32'd2);
        wr(A_CLR, 32'h1);
        wr(A_CTRL, 32'h7);
        rd(A_CTRL, v); check(v == 1, "R11 ctrl readback", v, 1);
        idle(12);
        rd(A_CNT, v);  check(v == 0, "R5 both bits one-shot", v, 0);
        rd(A_STAT, v); check(v[0] == 1, "R5 flag after one-shot", v[0], 1);
        check(irq_o == 0, "R8 irq masked", irq_o, 0);

        // R8: enabling irq with flag pending raises irq; clear drops it
        wr(A_CTRL, 32'h0);
        wr(A_IEN, 32'h1);
        check(irq_o == 1, "R8 irq after enable", irq_o, 1);
        wr(A_CLR, 32'h1);
        check(irq_o == 0, "R9 irq after clear", irq_o, 0);
        rd(A_STAT, v); check(v[0] == 0, "R9 flag cleared", v[0], 0);

        // R9: match in same cycle as clear keeps the flag
        wr(A_CTRL, 32'h1);
        wr(A_RLD, 32'd0);
        wr(A_CTRL, 32'h5);
        idle(3);
        wr(A_CLR, 32'h1);
        rd(A_STAT, v); check(v[0] == 1, "R9 match wins over clear", v[0], 1);
        wr(A_CTRL, 32'h0);
        wr(A_CLR, 32'h1);
        rd(A_STAT, v); check(v[0] == 0, "R9 clear when stopped", v[0], 0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule